// File: doc/BRIEF.md
# Exclusive Register Access Arbiter

This block guards the control register set of an embedded memory controller so that only one bus master at a time may read or change it. Every bus cycle carries a 2-bit identity of the master that issued it: system controller, processor, fabric or any other (DMA-type) master. A master claims the register set by writing a request code to an ownership register. It then reads that register back to learn whether the claim was granted, and hands the set back with a release code. While a master owns the set, its writes to the protected registers take effect and its reads return real data. Writes from every other master are dropped, and their reads of those registers return zero.

The ownership register, a status word and a small write-data buffer are open to all masters. A read buffer, filled from the memory side through a separate fill port, is visible only to the owner. A normal release wipes both buffers so that the next owner cannot see what the last one staged. The system controller can seize ownership at any moment with a dedicated code. A seizure clears nothing, so staged data survives it.

Top module: `reg_owner_guard`

## Requirements
- R1: After reset the ownership register reads 000, both buffers hold zero, and the protected control word and size field are zero.
- R2: A write of 0x01 to offset 0x1FC when nobody holds access grants it to the writer. A read of 0x1FC then returns {1, id}, where id is 00 system controller, 01 processor, 10 fabric, 11 other.
- R3: A 0x01 request while another master holds access is refused and the holder stays unchanged. The same request from the current holder changes nothing.
- R4: A write of 0x00 from the current holder releases access. Bit 2 then reads 0 and bits [1:0] keep the last holder's id. A 0x00 write from any other master is ignored.
- R5: A release clears every word of the write-data buffer (0x080 upward) and of the read buffer (0x000 upward) to zero, in the same clock edge.
- R6: A 0x03 write from the system controller takes ownership in that clock edge whatever the current owner, and leaves both buffers unchanged. A 0x03 write from any other master is ignored.
- R7: Writes to the control word (0x128) and to the 4-bit size field (0x144) from a master that does not hold access are ignored. Its reads of 0x128, 0x144 and the read buffer return zero.
- R8: Any master may read 0x1FC, read the status word, and read or write the write-data buffer, whether it holds access or not.
- R9: The ownership register accepts byte, halfword and word accesses (size code 0, 1 or 2) only at 0x1FC. Writes at 0x1FD to 0x1FF, and writes with size code 3, have no effect. Reads at 0x1FD to 0x1FF return zero.
- R10: The status word at 0x120 returns bit 3 = 1 when the reading master is the holder, with bits [2:0] equal to the ownership register.
- R11: A fill strobe writes fill data into the addressed read-buffer word at the next clock edge. If a release happens in the same edge, the clear wins.
- R12: Codes other than 0x00, 0x01 and 0x03 (compared on write-data bits [7:0]) written to 0x1FC are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busSel | input | 1 | Bus cycle valid |
| busWrite | input | 1 | 1 write, 0 read |
| busMaster | input | 2 | Identity of the issuing master |
| busAddr | input | 9 | Byte offset within the register set |
| busSize | input | 2 | Access size: 0 byte, 1 halfword, 2 word |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data, valid in the same cycle |
| fillEn | input | 1 | Read-buffer fill strobe from the memory side |
| fillIdx | input | IDX_W | Read-buffer word index for the fill |
| fillData | input | 32 | Fill data |

## Verification
A write or fill takes effect at the rising edge that closes its cycle. Read data is decoded combinationally from registered state, so it is valid within the same cycle as the read request. The bench drives every bus cycle at the falling edge. It samples read data 2 ns later, well before the next rising edge, and releases a write only after that edge has passed. Each read check therefore sees exactly the state left by all the earlier cycles. The cases covered include a release that coincides with a fill, and illegal offsets and sizes, each checked by a readback on the following cycle.

// File: rtl/reg_guard_pkg.sv
`timescale 1ns/1ps
package reg_guard_pkg;

  typedef enum logic [1:0] {
    MST_SYSCTL = 2'd0,
    MST_CPU    = 2'd1,
    MST_FABRIC = 2'd2,
    MST_OTHER  = 2'd3
  } master_e;

  typedef enum logic [2:0] {
    RD_NONE,
    RD_REQ,
    RD_STATUS,
    RD_WBUF,
    RD_RBUF,
    RD_CTRL,
    RD_SIZE
  } rdsel_e;

  // strobes from the ownership control to the datapath
  typedef struct packed {
    logic   wbufWe;
    logic   ctrlWe;
    logic   sizeWe;
    logic   clearBufs;
    rdsel_e rdSel;
  } strobe_t;

  localparam int RBUF_BASE   = 'h000;
  localparam int WBUF_BASE   = 'h080;
  localparam int STATUS_OFS  = 'h120;
  localparam int CTRL_OFS    = 'h128;
  localparam int SIZE_OFS    = 'h144;
  localparam int REQ_OFS     = 'h1FC;

  localparam logic [7:0] CODE_RELEASE = 8'h00;
  localparam logic [7:0] CODE_REQUEST = 8'h01;
  localparam logic [7:0] CODE_SEIZE   = 8'h03;

endpackage

// File: rtl/own_ctrl.sv
`timescale 1ns/1ps
module own_ctrl
  import reg_guard_pkg::*;
#(
  parameter int BUF_WORDS = 4
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          busSel,
  input  logic          busWrite,
  input  logic [1:0]    busMaster,
  input  logic [8:0]    busAddr,
  input  logic [1:0]    busSize,
  input  logic [7:0]    wrCode,
  output strobe_t       strobe,
  output logic          accHeld,
  output master_e       accHolder,
  output logic          reqIsOwner
);

  localparam int BUF_BYTES = BUF_WORDS * 4;

  master_e reqMaster;
  logic    hitRbuf, hitWbuf, hitStatus, hitCtrl, hitSize, hitReqBase, hitReqOdd;
  logic    reqLegal, wrCycle, rdCycle;
  logic    doGrant, doRelease, doSeize;

  assign reqMaster = master_e'(busMaster);
  assign wrCycle   = busSel && busWrite;
  assign rdCycle   = busSel && !busWrite;

  // address decode
  always_comb begin
    hitRbuf    = (int'(busAddr) >= RBUF_BASE) && (int'(busAddr) < RBUF_BASE + BUF_BYTES);
    hitWbuf    = (int'(busAddr) >= WBUF_BASE) && (int'(busAddr) < WBUF_BASE + BUF_BYTES);
    hitStatus  = int'(busAddr) == STATUS_OFS;
    hitCtrl    = int'(busAddr) == CTRL_OFS;
    hitSize    = int'(busAddr) == SIZE_OFS;
    hitReqBase = int'(busAddr) == REQ_OFS;
    hitReqOdd  = (busAddr[8:2] == 7'h7F) && (busAddr[1:0] != 2'b00);
  end

  assign reqLegal   = hitReqBase && (busSize != 2'b11);
  assign reqIsOwner = accHeld && (accHolder == reqMaster);

  // ownership transitions
  always_comb begin
    doGrant   = 1'b0;
    doRelease = 1'b0;
    doSeize   = 1'b0;
    if (wrCycle && reqLegal) begin
      unique case (wrCode)
        CODE_REQUEST: doGrant   = !accHeld;
        CODE_RELEASE: doRelease = reqIsOwner;
        CODE_SEIZE:   doSeize   = (reqMaster == MST_SYSCTL);
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      accHeld   <= 1'b0;
      accHolder <= MST_SYSCTL;
    end else if (doGrant || doSeize) begin
      accHeld   <= 1'b1;
      accHolder <= reqMaster;
    end else if (doRelease) begin
      accHeld   <= 1'b0;
    end
  end

  // strobes to the datapath
  always_comb begin
    strobe.wbufWe    = wrCycle && hitWbuf;
    strobe.ctrlWe    = wrCycle && hitCtrl && reqIsOwner;
    strobe.sizeWe    = wrCycle && hitSize && reqIsOwner;
    strobe.clearBufs = doRelease;
    strobe.rdSel     = RD_NONE;
    if (rdCycle) begin
      if (hitReqBase)                   strobe.rdSel = RD_REQ;
      else if (hitStatus)               strobe.rdSel = RD_STATUS;
      else if (hitWbuf)                 strobe.rdSel = RD_WBUF;
      else if (hitRbuf && reqIsOwner)   strobe.rdSel = RD_RBUF;
      else if (hitCtrl && reqIsOwner)   strobe.rdSel = RD_CTRL;
      else if (hitSize && reqIsOwner)   strobe.rdSel = RD_SIZE;
    end
  end

  // a free register set goes to the requester
  assert_grant_free_R2: assert property (@(posedge clk) disable iff (!rstN)
    (wrCycle && reqLegal && wrCode == CODE_REQUEST && !accHeld)
    |=> (accHeld && accHolder == $past(reqMaster)));

  // a competing request leaves the holder in place
  assert_refuse_busy_R3: assert property (@(posedge clk) disable iff (!rstN)
    (wrCycle && reqLegal && wrCode == CODE_REQUEST && accHeld && accHolder != reqMaster)
    |=> (accHeld && accHolder == $past(accHolder)));

  // a release from a non-holder changes nothing
  assert_foreign_release_R4: assert property (@(posedge clk) disable iff (!rstN)
    (wrCycle && reqLegal && wrCode == CODE_RELEASE && !reqIsOwner)
    |=> ($stable(accHeld) && $stable(accHolder)));

  // the system controller always wins with the seize code
  assert_seize_R6: assert property (@(posedge clk) disable iff (!rstN)
    (wrCycle && reqLegal && wrCode == CODE_SEIZE && reqMaster == MST_SYSCTL)
    |=> (accHeld && accHolder == MST_SYSCTL));

  // unaligned offsets of the ownership register are inert
  assert_odd_offset_R9: assert property (@(posedge clk) disable iff (!rstN)
    (wrCycle && hitReqOdd) |=> ($stable(accHeld) && $stable(accHolder)));

endmodule

// File: rtl/guard_datapath.sv
`timescale 1ns/1ps
module guard_datapath
  import reg_guard_pkg::*;
#(
  parameter int BUF_WORDS = 4,
  parameter int DATA_W    = 32,
  localparam int IDX_W    = $clog2(BUF_WORDS)
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           strobe,
  input  logic [IDX_W-1:0]  wordIdx,
  input  logic [DATA_W-1:0] busWdata,
  input  logic              accHeld,
  input  master_e           accHolder,
  input  logic              reqIsOwner,
  input  logic              fillEn,
  input  logic [IDX_W-1:0]  fillIdx,
  input  logic [DATA_W-1:0] fillData,
  output logic [DATA_W-1:0] rdData
);

  localparam int SIZE_W = 4;

  logic [DATA_W-1:0] wbuf [BUF_WORDS];
  logic [DATA_W-1:0] rbuf [BUF_WORDS];
  logic [DATA_W-1:0] ctrlWord;
  logic [SIZE_W-1:0] sizeField;
  logic              bufsDirty;

  for (genvar gi = 0; gi < BUF_WORDS; gi++) begin : g_buf
    always_ff @(posedge clk) begin
      if (!rstN || strobe.clearBufs) begin
        wbuf[gi] <= '0;
      end else if (strobe.wbufWe && int'(wordIdx) == gi) begin
        wbuf[gi] <= busWdata;
      end
    end

    always_ff @(posedge clk) begin
      if (!rstN || strobe.clearBufs) begin
        rbuf[gi] <= '0;
      end else if (fillEn && int'(fillIdx) == gi) begin
        rbuf[gi] <= fillData;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ctrlWord  <= '0;
      sizeField <= '0;
    end else begin
      if (strobe.ctrlWe) ctrlWord  <= busWdata;
      if (strobe.sizeWe) sizeField <= busWdata[SIZE_W-1:0];
    end
  end

  always_comb begin
    rdData = '0;
    unique case (strobe.rdSel)
      RD_REQ:    rdData[2:0] = {accHeld, accHolder};
      RD_STATUS: rdData[3:0] = {reqIsOwner, accHeld, accHolder};
      RD_WBUF:   rdData = wbuf[wordIdx];
      RD_RBUF:   rdData = rbuf[wordIdx];
      RD_CTRL:   rdData = ctrlWord;
      RD_SIZE:   rdData[SIZE_W-1:0] = sizeField;
      default:   rdData = '0;
    endcase
  end

  always_comb begin
    bufsDirty = 1'b0;
    for (int i = 0; i < BUF_WORDS; i++) begin
      bufsDirty = bufsDirty || (wbuf[i] != '0) || (rbuf[i] != '0);
    end
  end

  // a release leaves no staged data behind
  assert_clear_on_release_R5: assert property (@(posedge clk) disable iff (!rstN)
    strobe.clearBufs |=> !bufsDirty);

  // a fill lands unless a release coincides
  assert_fill_lands_R11: assert property (@(posedge clk) disable iff (!rstN)
    (fillEn && !strobe.clearBufs) |=> (rbuf[$past(fillIdx)] == $past(fillData)));

  // decoded-out reads return zero
  assert_gated_read_R7: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.rdSel == RD_NONE) |-> (rdData == '0));

endmodule

// File: rtl/reg_owner_guard.sv
`timescale 1ns/1ps
module reg_owner_guard
  import reg_guard_pkg::*;
#(
  parameter int  BUF_WORDS = 4,
  localparam int IDX_W     = $clog2(BUF_WORDS)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             busSel,
  input  logic             busWrite,
  input  logic [1:0]       busMaster,
  input  logic [8:0]       busAddr,
  input  logic [1:0]       busSize,
  input  logic [31:0]      busWdata,
  output logic [31:0]      busRdata,
  input  logic             fillEn,
  input  logic [IDX_W-1:0] fillIdx,
  input  logic [31:0]      fillData
);

  strobe_t strobe;
  logic    accHeld;
  master_e accHolder;
  logic    reqIsOwner;

  own_ctrl #(.BUF_WORDS(BUF_WORDS)) u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .busSel     (busSel),
    .busWrite   (busWrite),
    .busMaster  (busMaster),
    .busAddr    (busAddr),
    .busSize    (busSize),
    .wrCode     (busWdata[7:0]),
    .strobe     (strobe),
    .accHeld    (accHeld),
    .accHolder  (accHolder),
    .reqIsOwner (reqIsOwner)
  );

  guard_datapath #(.BUF_WORDS(BUF_WORDS), .DATA_W(32)) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .wordIdx    (busAddr[2 +: IDX_W]),
    .busWdata   (busWdata),
    .accHeld    (accHeld),
    .accHolder  (accHolder),
    .reqIsOwner (reqIsOwner),
    .fillEn     (fillEn),
    .fillIdx    (fillIdx),
    .fillData   (fillData),
    .rdData     (busRdata)
  );

endmodule

// File: tb/reg_owner_guard_tb.sv
`timescale 1ns/1ps
module reg_owner_guard_tb;

  localparam int BUF_WORDS = 4;
  localparam int IDX_W     = $clog2(BUF_WORDS);

  logic             clk = 1'b0;
  logic             rstN = 1'b0;
  logic             busSel = 1'b0;
  logic             busWrite = 1'b0;
  logic [1:0]       busMaster = '0;
  logic [8:0]       busAddr = '0;
  logic [1:0]       busSize = '0;
  logic [31:0]      busWdata = '0;
  logic [31:0]      busRdata;
  logic             fillEn = 1'b0;
  logic [IDX_W-1:0] fillIdx = '0;
  logic [31:0]      fillData = '0;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;  // 50 MHz

  reg_owner_guard #(.BUF_WORDS(BUF_WORDS)) u_dut (
    .clk(clk), .rstN(rstN), .busSel(busSel), .busWrite(busWrite),
    .busMaster(busMaster), .busAddr(busAddr), .busSize(busSize),
    .busWdata(busWdata), .busRdata(busRdata), .fillEn(fillEn),
    .fillIdx(fillIdx), .fillData(fillData)
  );

  typedef struct packed {
    logic        rd;
    logic [1:0]  mst;
    logic [8:0]  addr;
    logic [1:0]  sz;
    logic [31:0] data;
    logic [31:0] exp;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 42;
  // masters: 0 sysctl, 1 cpu, 2 fabric, 3 other
  localparam vec_t VECS [NV] = '{
    '{1'b1, 2'd1, 9'h1FC, 2'd2, 32'h0,        32'h0,        4'd1},  // R1 idle readback
    '{1'b1, 2'd1, 9'h128, 2'd2, 32'h0,        32'h0,        4'd1},  // R1
    '{1'b0, 2'd1, 9'h1FC, 2'd2, 32'h1,        32'h0,        4'd2},  // cpu requests
    '{1'b1, 2'd1, 9'h1FC, 2'd2, 32'h0,        32'h5,        4'd2},  // R2 granted
    '{1'b0, 2'd2, 9'h1FC, 2'd0, 32'h1,        32'h0,        4'd3},  // fabric competes
    '{1'b1, 2'd2, 9'h1FC, 2'd2, 32'h0,        32'h5,        4'd3},  // R3 refused
    '{1'b0, 2'd1, 9'h1FC, 2'd0, 32'h1,        32'h0,        4'd3},  // owner re-requests
    '{1'b1, 2'd1, 9'h1FC, 2'd2, 32'h0,        32'h5,        4'd3},  // R3 unchanged
    '{1'b0, 2'd1, 9'h128, 2'd2, 32'hA5A50001, 32'h0,        4'd7},
    '{1'b1, 2'd1, 9'h128, 2'd2, 32'h0,        32'hA5A50001, 4'd7},  // R7 owner sees it
    '{1'b0, 2'd2, 9'h128, 2'd2, 32'hFFFFFFFF, 32'h0,        4'd7},  // foreign write
    '{1'b1, 2'd2, 9'h128, 2'd2, 32'h0,        32'h0,        4'd7},  // R7 read gated
    '{1'b1, 2'd1, 9'h128, 2'd2, 32'h0,        32'hA5A50001, 4'd7},  // R7 write dropped
    '{1'b0, 2'd2, 9'h080, 2'd2, 32'h11112222, 32'h0,        4'd8},
    '{1'b1, 2'd3, 9'h080, 2'd2, 32'h0,        32'h11112222, 4'd8},  // R8 open buffer
    '{1'b1, 2'd2, 9'h120, 2'd2, 32'h0,        32'h5,        4'd10}, // R10 non-holder
    '{1'b1, 2'd1, 9'h120, 2'd2, 32'h0,        32'hD,        4'd10}, // R10 holder
    '{1'b1, 2'd3, 9'h1FC, 2'd2, 32'h0,        32'h5,        4'd8},  // R8
    '{1'b0, 2'd2, 9'h1FC, 2'd2, 32'h0,        32'h0,        4'd4},  // foreign release
    '{1'b1, 2'd1, 9'h1FC, 2'd2, 32'h0,        32'h5,        4'd4},  // R4 ignored
    '{1'b0, 2'd1, 9'h1FD, 2'd0, 32'h0,        32'h0,        4'd9},  // odd offset
    '{1'b1, 2'd1, 9'h1FC, 2'd2, 32'h0,        32'h5,        4'd9},  // R9
    '{1'b1, 2'd1, 9'h1FD, 2'd0, 32'h0,        32'h0,        4'd9},  // R9 odd read
    '{1'b0, 2'd1, 9'h1FC, 2'd3, 32'h0,        32'h0,        4'd9},  // illegal size
    '{1'b1, 2'd1, 9'h1FC, 2'd2, 32'h0,        32'h5,        4'd9},  // R9
    '{1'b0, 2'd1, 9'h1FC, 2'd1, 32'h0,        32'h0,        4'd4},  // halfword release
    '{1'b1, 2'd3, 9'h1FC, 2'd2, 32'h0,        32'h1,        4'd4},  // R4 last holder
    '{1'b1, 2'd3, 9'h080, 2'd2, 32'h0,        32'h0,        4'd5},  // R5 cleared
    '{1'b0, 2'd3, 9'h1FC, 2'd2, 32'h2,        32'h0,        4'd12},
    '{1'b1, 2'd3, 9'h1FC, 2'd2, 32'h0,        32'h1,        4'd12}, // R12
    '{1'b0, 2'd3, 9'h1FC, 2'd2, 32'h1,        32'h0,        4'd2},
    '{1'b1, 2'd3, 9'h1FC, 2'd2, 32'h0,        32'h7,        4'd2},  // R2 other
    '{1'b0, 2'd3, 9'h144, 2'd2, 32'hFF,       32'h0,        4'd7},
    '{1'b1, 2'd3, 9'h144, 2'd2, 32'h0,        32'hF,        4'd7},  // R7 size field
    '{1'b0, 2'd3, 9'h088, 2'd2, 32'hCAFE,     32'h0,        4'd8},
    '{1'b0, 2'd2, 9'h1FC, 2'd2, 32'h3,        32'h0,        4'd6},  // fabric seize
    '{1'b1, 2'd2, 9'h1FC, 2'd2, 32'h0,        32'h7,        4'd6},  // R6 ignored
    '{1'b0, 2'd0, 9'h1FC, 2'd2, 32'h3,        32'h0,        4'd6},  // sysctl seize
    '{1'b1, 2'd3, 9'h1FC, 2'd2, 32'h0,        32'h4,        4'd6},  // R6 taken
    '{1'b1, 2'd3, 9'h088, 2'd2, 32'h0,        32'hCAFE,     4'd6},  // R6 kept
    '{1'b1, 2'd3, 9'h144, 2'd2, 32'h0,        32'h0,        4'd7},  // R7 gated
    '{1'b1, 2'd0, 9'h144, 2'd2, 32'h0,        32'hF,        4'd6}   // R6 regs kept
  };

  task automatic checkVal(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // one bus cycle: drive at falling edge, sample reads 2 ns later
  task automatic busOp(input logic rd, input logic [1:0] mst, input logic [8:0] addr,
                       input logic [1:0] sz, input logic [31:0] data,
                       input logic [31:0] exp, input string tag);
    @(negedge clk);
    busSel = 1'b1; busWrite = !rd; busMaster = mst;
    busAddr = addr; busSize = sz; busWdata = data;
    #2;
    if (rd) checkVal(tag, busRdata, exp);
    @(posedge clk);
    #1;
    busSel = 1'b0; busWrite = 1'b0;
  endtask

  task automatic fillOnly(input logic [IDX_W-1:0] idx, input logic [31:0] data);
    @(negedge clk);
    fillEn = 1'b1; fillIdx = idx; fillData = data;
    @(posedge clk);
    #1;
    fillEn = 1'b0;
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  endtask

  initial begin
    #(20 * 100000);
    checks++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finishRun();
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;

    for (int i = 0; i < NV; i++) begin
      busOp(VECS[i].rd, VECS[i].mst, VECS[i].addr, VECS[i].sz, VECS[i].data,
            VECS[i].exp, $sformatf("R%0d vec%0d", VECS[i].req, i));
    end

    // R11: fill while sysctl holds access, holder reads it back
    fillOnly(1, 32'hBEEF);
    busOp(1'b1, 2'd0, 9'h004, 2'd2, 0, 32'hBEEF, "R11 fill readback");
    busOp(1'b1, 2'd1, 9'h004, 2'd2, 0, 32'h0,    "R7 read buffer gated");

    // R5: release wipes both buffers
    busOp(1'b0, 2'd0, 9'h1FC, 2'd0, 32'h0, 0, "R5 release");
    busOp(1'b1, 2'd0, 9'h088, 2'd2, 0, 32'h0, "R5 write buffer cleared");
    busOp(1'b1, 2'd0, 9'h1FC, 2'd2, 0, 32'h0, "R4 sysctl released");
    busOp(1'b0, 2'd0, 9'h1FC, 2'd2, 32'h1, 0, "R2 sysctl request");
    busOp(1'b1, 2'd0, 9'h004, 2'd2, 0, 32'h0, "R5 read buffer cleared");

    // R11: a fill coinciding with a release is lost
    @(negedge clk);
    fillEn = 1'b1; fillIdx = 0; fillData = 32'h1234;
    busOp(1'b0, 2'd0, 9'h1FC, 2'd2, 32'h0, 0, "R11 release with fill");
    fillEn = 1'b0;
    busOp(1'b0, 2'd0, 9'h1FC, 2'd2, 32'h1, 0, "R2 regrant");
    busOp(1'b1, 2'd0, 9'h000, 2'd2, 0, 32'h0, "R11 clear wins");

    // R1: reset in mid-run
    busOp(1'b0, 2'd0, 9'h084, 2'd2, 32'h77, 0, "R8 stage");
    busOp(1'b0, 2'd0, 9'h144, 2'd2, 32'h9, 0, "R7 stage size");
    @(negedge clk); rstN = 1'b0;
    @(negedge clk); rstN = 1'b1;
    busOp(1'b1, 2'd2, 9'h1FC, 2'd2, 0, 32'h0, "R1 owner after reset");
    busOp(1'b1, 2'd2, 9'h084, 2'd2, 0, 32'h0, "R1 buffer after reset");
    busOp(1'b0, 2'd2, 9'h1FC, 2'd2, 32'h1, 0, "R2 fabric request");
    busOp(1'b1, 2'd2, 9'h1FC, 2'd2, 0, 32'h6, "R2 fabric granted");
    busOp(1'b1, 2'd2, 9'h144, 2'd2, 0, 32'h0, "R1 size after reset");

    finishRun();
  end

endmodule